// File: doc/BRIEF.md
# Blocking Two-Port Memory Forwarder

This block joins two upstream requesters to one downstream memory port. One requester carries instruction fetches and the other carries data accesses. Only one transaction may be open at a time. While a transaction is open, every new upstream request is refused, and the forwarder records that the refused port is owed a retry. When the transaction completes, that port receives a one-cycle retry pulse.

Every send is a one-cycle attempt. The sender drives valid, and the receiver answers with ready in the same cycle. If a send is refused, its payload stays in a holding register. The payload is sent again in the cycle after the far side pulses its retry line. This applies to the request going down to memory and to the response going back up to each requester. Memory responses are always taken, and each one is steered back by the fetch tag that travelled with its request. A combinational error output reports protocol violations by the neighbours.

Top module: `blocking_fwd`

## Requirements
- R1: After reset nothing is open: both request readies are high, no valid is driven on any output channel, no retry pulse is driven and the error output is low.
- R2: When idle, a request is accepted in the cycle it is presented, with ready high in that cycle. In the next cycle it appears on the memory request port with unchanged address, command, size and data. Its fetch tag is 1 for the instruction port and 0 for the data port.
- R3: From the cycle after an acceptance until the memory response arrives, both request readies are low, and any request presented on either port is refused.
- R4: If both ports request in the same idle cycle, the instruction port is accepted and the data port is refused.
- R5: If memory drops the ready on a forwarded request, memory valid goes low in the next cycle. The same request is presented again in the cycle after a memory request-retry pulse.
- R6: A memory response taken while a transaction is open is presented in the next cycle with its data. It goes to the instruction port when the returned fetch tag is 1 and to the data port when the tag is 0. A new request is accepted in the cycle after the response.
- R7: If an upstream port drops the ready on a response, that port's response valid goes low in the next cycle. The same data is presented again in the cycle after that port's response-retry pulse.
- R8: Two cycles after a memory response is taken, each port that is owed a retry and holds no stalled response gets a retry pulse lasting exactly one cycle. Its owed state is then cleared, so a later response produces no further pulse.
- R9: The error output is high in any cycle that has one of these violations: a memory response with no open transaction, a memory request-retry with no stalled request, a response-retry on a port that holds nothing, or a response aimed at a port that still holds a stalled response. A response with no open transaction is dropped, and so is a response aimed at a port that is still holding one. A port's held response is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iReqValid | input | 1 | Instruction request attempt |
| iReqReady | output | 1 | Instruction request accepted this cycle |
| iReqAddr | input | ADDR_W | Instruction request address |
| iReqWrite | input | 1 | Instruction request command (1 = write) |
| iReqSize | input | SIZE_W | Instruction request size |
| iReqData | input | DATA_W | Instruction request write data |
| iRetryReq | output | 1 | Pulse: instruction port may request again |
| iRespValid | output | 1 | Instruction response attempt |
| iRespReady | input | 1 | Instruction response taken |
| iRespData | output | DATA_W | Instruction response data |
| iRespRetry | input | 1 | Pulse: resend stalled instruction response |
| dReqValid | input | 1 | Data request attempt |
| dReqReady | output | 1 | Data request accepted this cycle |
| dReqAddr | input | ADDR_W | Data request address |
| dReqWrite | input | 1 | Data request command (1 = write) |
| dReqSize | input | SIZE_W | Data request size |
| dReqData | input | DATA_W | Data request write data |
| dRetryReq | output | 1 | Pulse: data port may request again |
| dRespValid | output | 1 | Data response attempt |
| dRespReady | input | 1 | Data response taken |
| dRespData | output | DATA_W | Data response data |
| dRespRetry | input | 1 | Pulse: resend stalled data response |
| mReqValid | output | 1 | Memory request attempt |
| mReqReady | input | 1 | Memory request taken |
| mReqAddr | output | ADDR_W | Memory request address |
| mReqWrite | output | 1 | Memory request command |
| mReqSize | output | SIZE_W | Memory request size |
| mReqData | output | DATA_W | Memory request data |
| mReqFetch | output | 1 | Fetch tag (1 = from instruction port) |
| mReqRetry | input | 1 | Pulse: resend stalled memory request |
| mRespValid | input | 1 | Memory response (always taken) |
| mRespData | input | DATA_W | Memory response data |
| mRespFetch | input | 1 | Returned fetch tag |
| protoErr | output | 1 | Protocol violation seen this cycle |

## Verification
The embedded properties assume well-behaved neighbours. Memory answers only while a transaction is open, and it pulses its request-retry only after refusing a request. Each requester pulses its response-retry only after refusing a response, and it issues a new request only once its previous response has been taken. The random stimulus keeps to these rules through small agent state machines: a refused requester waits for its retry pulse, memory models a latency counter and a retry countdown, and each response refusal schedules exactly one retry. The violations are injected only in a directed segment, where they are checked at the error output and at the response ports rather than by the properties.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NPORT  = 2;
  localparam int PORT_I = 0;
  localparam int PORT_D = 1;

  typedef struct packed {
    logic             loadFromI;
    logic             loadFromD;
    logic [NPORT-1:0] loadResp;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPORT-1:0] reqValid,
  output logic [NPORT-1:0] reqReady,
  output logic [NPORT-1:0] retryReq,
  output logic [NPORT-1:0] respValid,
  input  logic [NPORT-1:0] respReady,
  input  logic [NPORT-1:0] respRetry,
  output logic             mReqValid,
  input  logic             mReqReady,
  input  logic             mReqRetry,
  input  logic             mRespValid,
  input  logic             mRespFetch,
  output logic             protoErr,
  output fwdStrobe_t       strobe
);
  logic busy, busyN;
  logic reqTry, reqTryN, reqWait, reqWaitN;
  logic rspEvt;
  logic [NPORT-1:0] owed, owedN, retryQ, give;
  logic [NPORT-1:0] rspTry, rspTryN, rspWait, rspWaitN;
  logic [NPORT-1:0] grant, refuse, held, deliver;
  logic rspGood, tgt, clash, strayRetry;

  always_comb begin
    grant[PORT_I]    = reqValid[PORT_I] && !busy;
    grant[PORT_D]    = reqValid[PORT_D] && !busy && !reqValid[PORT_I];
    refuse           = reqValid & ~grant;
    reqReady[PORT_I] = !busy;
    reqReady[PORT_D] = !busy && !reqValid[PORT_I];
    rspGood          = mRespValid && busy;
    tgt              = !mRespFetch;
    for (int p = 0; p < NPORT; p++) begin
      held[p]     = (rspTry[p] && !respReady[p]) || rspWait[p];
      deliver[p]  = rspGood && (tgt == 1'(p)) && !held[p];
      rspWaitN[p] = (rspTry[p] && !respReady[p]) || (rspWait[p] && !respRetry[p]);
      rspTryN[p]  = deliver[p] || (rspWait[p] && respRetry[p]);
      give[p]     = rspEvt && owed[p] && !rspTryN[p] && !rspWaitN[p];
    end
    clash      = rspGood && held[tgt];
    owedN      = (owed & ~give) | refuse;
    reqTryN    = (|grant) || (reqWait && mReqRetry);
    reqWaitN   = (reqTry && !mReqReady) || (reqWait && !mReqRetry);
    busyN      = busy ? !rspGood : (|grant);
    strayRetry = (mReqRetry && !reqWait) || (|(respRetry & ~rspWait));
    protoErr   = (mRespValid && !busy) || strayRetry || clash;
    strobe.loadFromI = grant[PORT_I];
    strobe.loadFromD = grant[PORT_D];
    strobe.loadResp  = deliver;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      reqTry  <= 1'b0;
      reqWait <= 1'b0;
      rspEvt  <= 1'b0;
      owed    <= '0;
      retryQ  <= '0;
      rspTry  <= '0;
      rspWait <= '0;
    end else begin
      busy    <= busyN;
      reqTry  <= reqTryN;
      reqWait <= reqWaitN;
      rspEvt  <= rspGood;
      owed    <= owedN;
      retryQ  <= give;
      rspTry  <= rspTryN;
      rspWait <= rspWaitN;
    end
  end

  assign mReqValid = reqTry;
  assign respValid = rspTry;
  assign retryReq  = retryQ;

  AST_ACCEPT_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqValid & reqReady)) |=> mReqValid); // R2
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqValid & reqReady)) |=> (reqReady == '0)); // R3
  AST_I_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid[PORT_I] && reqValid[PORT_D]) |-> !reqReady[PORT_D]); // R4
  AST_MEM_STALL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (mReqValid && !mReqReady) |=> !mReqValid); // R5
  AST_ROUTE_I: assert property (@(posedge clk) disable iff (!rstN)
    (rspGood && mRespFetch && !held[PORT_I]) |=> respValid[PORT_I]); // R6
  AST_RESP_STALL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (respValid[PORT_D] && !respReady[PORT_D]) |=> !respValid[PORT_D]); // R7
  AST_RETRY_I_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    retryReq[PORT_I] |=> !retryReq[PORT_I]); // R8
  AST_RETRY_D_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    retryReq[PORT_D] |=> !retryReq[PORT_D]); // R8
endmodule

// File: rtl/fwd_dpath.sv
module fwd_dpath
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  fwdStrobe_t        strobe,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic              iWrite,
  input  logic [SIZE_W-1:0] iSize,
  input  logic [DATA_W-1:0] iData,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic              dWrite,
  input  logic [SIZE_W-1:0] dSize,
  input  logic [DATA_W-1:0] dData,
  input  logic [DATA_W-1:0] mRespData,
  output logic [ADDR_W-1:0] mAddr,
  output logic              mWrite,
  output logic [SIZE_W-1:0] mSize,
  output logic [DATA_W-1:0] mData,
  output logic              mFetch,
  output logic [DATA_W-1:0] iRespData,
  output logic [DATA_W-1:0] dRespData
);
  logic [DATA_W-1:0] rspBuf [NPORT];

  always_ff @(posedge clk) begin
    if (strobe.loadFromI || strobe.loadFromD) begin
      mAddr  <= strobe.loadFromI ? iAddr  : dAddr;
      mWrite <= strobe.loadFromI ? iWrite : dWrite;
      mSize  <= strobe.loadFromI ? iSize  : dSize;
      mData  <= strobe.loadFromI ? iData  : dData;
      mFetch <= strobe.loadFromI;
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : gRspBuf
    always_ff @(posedge clk) begin
      if (strobe.loadResp[g]) rspBuf[g] <= mRespData;
    end
  end

  assign iRespData = rspBuf[PORT_I];
  assign dRespData = rspBuf[PORT_D];
endmodule

// File: rtl/blocking_fwd.sv
module blocking_fwd
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iReqValid,
  output logic              iReqReady,
  input  logic [ADDR_W-1:0] iReqAddr,
  input  logic              iReqWrite,
  input  logic [SIZE_W-1:0] iReqSize,
  input  logic [DATA_W-1:0] iReqData,
  output logic              iRetryReq,
  output logic              iRespValid,
  input  logic              iRespReady,
  output logic [DATA_W-1:0] iRespData,
  input  logic              iRespRetry,
  input  logic              dReqValid,
  output logic              dReqReady,
  input  logic [ADDR_W-1:0] dReqAddr,
  input  logic              dReqWrite,
  input  logic [SIZE_W-1:0] dReqSize,
  input  logic [DATA_W-1:0] dReqData,
  output logic              dRetryReq,
  output logic              dRespValid,
  input  logic              dRespReady,
  output logic [DATA_W-1:0] dRespData,
  input  logic              dRespRetry,
  output logic              mReqValid,
  input  logic              mReqReady,
  output logic [ADDR_W-1:0] mReqAddr,
  output logic              mReqWrite,
  output logic [SIZE_W-1:0] mReqSize,
  output logic [DATA_W-1:0] mReqData,
  output logic              mReqFetch,
  input  logic              mReqRetry,
  input  logic              mRespValid,
  input  logic [DATA_W-1:0] mRespData,
  input  logic              mRespFetch,
  output logic              protoErr
);
  fwdStrobe_t       strobe;
  logic [NPORT-1:0] reqReady, retryReq, respValid;

  fwd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   ({dReqValid, iReqValid}),
    .reqReady   (reqReady),
    .retryReq   (retryReq),
    .respValid  (respValid),
    .respReady  ({dRespReady, iRespReady}),
    .respRetry  ({dRespRetry, iRespRetry}),
    .mReqValid  (mReqValid),
    .mReqReady  (mReqReady),
    .mReqRetry  (mReqRetry),
    .mRespValid (mRespValid),
    .mRespFetch (mRespFetch),
    .protoErr   (protoErr),
    .strobe     (strobe)
  );

  fwd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_dpath (
    .clk       (clk),
    .strobe    (strobe),
    .iAddr     (iReqAddr),
    .iWrite    (iReqWrite),
    .iSize     (iReqSize),
    .iData     (iReqData),
    .dAddr     (dReqAddr),
    .dWrite    (dReqWrite),
    .dSize     (dReqSize),
    .dData     (dReqData),
    .mRespData (mRespData),
    .mAddr     (mReqAddr),
    .mWrite    (mReqWrite),
    .mSize     (mReqSize),
    .mData     (mReqData),
    .mFetch    (mReqFetch),
    .iRespData (iRespData),
    .dRespData (dRespData)
  );

  assign iReqReady  = reqReady[PORT_I];
  assign dReqReady  = reqReady[PORT_D];
  assign iRetryReq  = retryReq[PORT_I];
  assign dRetryReq  = retryReq[PORT_D];
  assign iRespValid = respValid[PORT_I];
  assign dRespValid = respValid[PORT_D];

  AST_REPLAY_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (mReqValid && !mReqReady) |=> ($stable(mReqAddr) && $stable(mReqData) && $stable(mReqFetch))); // R5
  AST_RESP_HELD_I: assert property (@(posedge clk) disable iff (!rstN)
    (iRespValid && !iRespReady) |=> $stable(iRespData)); // R7
endmodule

// File: tb/blocking_fwd_tb.sv
module blocking_fwd_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  reqV, reqW, respRdy, respRty;
  logic [31:0] reqA [2];
  logic [31:0] reqD [2];
  logic [2:0]  reqS [2];
  logic [1:0]  reqRdy, retryP, respV;
  logic [31:0] respD [2];
  logic        mReqValid, mReqReady, mReqWrite, mReqFetch, mReqRetry;
  logic        mRespValid, mRespFetch, protoErr;
  logic [31:0] mReqAddr, mReqData, mRespData;
  logic [2:0]  mReqSize;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  blocking_fwd u_dut (
    .clk(clk), .rstN(rstN),
    .iReqValid(reqV[0]), .iReqReady(reqRdy[0]), .iReqAddr(reqA[0]), .iReqWrite(reqW[0]),
    .iReqSize(reqS[0]), .iReqData(reqD[0]), .iRetryReq(retryP[0]), .iRespValid(respV[0]),
    .iRespReady(respRdy[0]), .iRespData(respD[0]), .iRespRetry(respRty[0]),
    .dReqValid(reqV[1]), .dReqReady(reqRdy[1]), .dReqAddr(reqA[1]), .dReqWrite(reqW[1]),
    .dReqSize(reqS[1]), .dReqData(reqD[1]), .dRetryReq(retryP[1]), .dRespValid(respV[1]),
    .dRespReady(respRdy[1]), .dRespData(respD[1]), .dRespRetry(respRty[1]),
    .mReqValid(mReqValid), .mReqReady(mReqReady), .mReqAddr(mReqAddr), .mReqWrite(mReqWrite),
    .mReqSize(mReqSize), .mReqData(mReqData), .mReqFetch(mReqFetch), .mReqRetry(mReqRetry),
    .mRespValid(mRespValid), .mRespData(mRespData), .mRespFetch(mRespFetch), .protoErr(protoErr)
  );

  function automatic logic [31:0] memVal(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0000_1234;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    reqV = '0; respRty = '0; respRdy = 2'b11;
    mReqReady = 1'b1; mReqRetry = 1'b0; mRespValid = 1'b0; mRespFetch = 1'b0;
  endtask

  task automatic nxt();
    @(negedge clk);
    quiet();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finishRun();
  end

  int st [2];
  int rtyCnt [2];
  logic [31:0] expA [2];
  int mRtyCnt, latCnt, completed, errSeen;
  logic [31:0] memAddr;
  logic memTag;

  initial begin
    for (int p = 0; p < 2; p++) begin
      reqA[p] = '0; reqD[p] = '0; reqS[p] = '0;
    end
    reqW = '0; mRespData = '0;
    quiet();
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    nxt(); #5;
    chk(reqRdy == 2'b11, "R1 ready", 32'(reqRdy), 32'h3);
    chk(!mReqValid && respV == 2'b00, "R1 valids", {30'b0, mReqValid, |respV}, 0);
    chk(retryP == 2'b00 && !protoErr, "R1 retry/err", {29'b0, protoErr, retryP}, 0);

    // R4 both request when idle
    nxt(); reqV = 2'b11; reqA[0] = 32'h100; reqA[1] = 32'h200; reqW = 2'b00; reqS[0] = 3'd2; reqD[0] = 32'h11; #5;
    chk(reqRdy[0] && !reqRdy[1], "R4 priority", 32'(reqRdy), 32'h1);
    // R2 forwarded, R5 memory refuses, R3 data refused while busy
    nxt(); reqV[1] = 1'b1; mReqReady = 1'b0; #5;
    chk(mReqValid && mReqAddr == 32'h100, "R2 forward addr", mReqAddr, 32'h100);
    chk(mReqFetch == 1'b1 && mReqSize == 3'd2 && mReqData == 32'h11 && !mReqWrite, "R2 fields", {mReqData[27:0], mReqSize, mReqFetch}, {28'h11, 3'd2, 1'b1});
    chk(reqRdy == 2'b00, "R3 busy refuse", 32'(reqRdy), 0);
    nxt(); #5;
    chk(!mReqValid, "R5 drop after refusal", 32'(mReqValid), 0);
    nxt(); mReqRetry = 1'b1; #5;
    chk(!protoErr && !mReqValid, "R5 retry cycle", {30'b0, protoErr, mReqValid}, 0);
    nxt(); #5;
    chk(mReqValid && mReqAddr == 32'h100, "R5 replay", mReqAddr, 32'h100);
    nxt(); mRespValid = 1'b1; mRespFetch = 1'b1; mRespData = 32'hAAAA; #5;
    chk(!protoErr, "R9 legal response", 32'(protoErr), 0);
    // R6 routed to instruction port; R7 refuse it
    nxt(); respRdy[0] = 1'b0; #5;
    chk(respV == 2'b01 && respD[0] == 32'hAAAA, "R6 route instr", respD[0], 32'hAAAA);
    chk(reqRdy[0], "R6 idle after response", 32'(reqRdy[0]), 1);
    nxt(); respRdy[0] = 1'b0; #5;
    chk(retryP == 2'b10, "R8 retry pulse to owed data port", 32'(retryP), 32'h2);
    chk(!respV[0], "R7 drop after refusal", 32'(respV[0]), 0);
    nxt(); respRty[0] = 1'b1; #5;
    chk(retryP == 2'b00 && !protoErr, "R8 pulse one cycle", 32'(retryP), 0);
    nxt(); #5;
    chk(respV[0] && respD[0] == 32'hAAAA, "R7 replay", respD[0], 32'hAAAA);

    // data port write
    nxt(); reqV[1] = 1'b1; reqA[1] = 32'h300; reqW[1] = 1'b1; reqD[1] = 32'h55; reqS[1] = 3'd5; #5;
    chk(reqRdy[1], "R2 data accepted", 32'(reqRdy[1]), 1);
    nxt(); #5;
    chk(mReqValid && mReqAddr == 32'h300 && mReqWrite && mReqData == 32'h55 && mReqSize == 3'd5 && !mReqFetch,
        "R2 data forward", mReqAddr, 32'h300);
    nxt(); mRespValid = 1'b1; mRespFetch = 1'b0; mRespData = 32'hBBBB; #5;
    nxt(); #5;
    chk(respV == 2'b10 && respD[1] == 32'hBBBB, "R6 route data", respD[1], 32'hBBBB);
    nxt(); #5;
    chk(retryP == 2'b00, "R8 owed cleared", 32'(retryP), 0);

    // R9 violations
    nxt(); mRespValid = 1'b1; mRespFetch = 1'b1; mRespData = 32'hDEAD; #5;
    chk(protoErr, "R9 response while idle", 32'(protoErr), 1);
    nxt(); mReqRetry = 1'b1; #5;
    chk(protoErr && respV == 2'b00, "R9 stray mem retry / idle response dropped", {30'b0, protoErr, |respV}, 32'h2);
    nxt(); respRty[1] = 1'b1; #5;
    chk(protoErr, "R9 stray response retry", 32'(protoErr), 1);
    nxt(); reqV[0] = 1'b1; reqA[0] = 32'h400; #5;
    nxt(); #5;
    nxt(); mRespValid = 1'b1; mRespFetch = 1'b1; mRespData = 32'h1; #5;
    nxt(); respRdy[0] = 1'b0; #5;
    nxt(); reqV[1] = 1'b1; reqA[1] = 32'h500; #5;
    chk(reqRdy[1], "R6 accept while response held", 32'(reqRdy[1]), 1);
    nxt(); #5;
    nxt(); mRespValid = 1'b1; mRespFetch = 1'b1; mRespData = 32'h2; #5;
    chk(protoErr, "R9 response to holding port", 32'(protoErr), 1);
    nxt(); #5;
    chk(respV == 2'b00, "R9 clashing response dropped", 32'(respV), 0);
    nxt(); respRty[0] = 1'b1; #5;
    nxt(); #5;
    chk(respV[0] && respD[0] == 32'h1, "R9 held response kept", respD[0], 32'h1);

    // constrained random traffic
    for (int p = 0; p < 2; p++) begin st[p] = 0; rtyCnt[p] = 0; expA[p] = '0; end
    mRtyCnt = 0; latCnt = 0; completed = 0; errSeen = 0; memAddr = '0; memTag = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      nxt();
      for (int p = 0; p < 2; p++) begin
        reqV[p] = (st[p] == 0) && ($urandom % 3 == 0) && (cyc < 3900);
        reqA[p] = $urandom; reqD[p] = $urandom; reqW[p] = 1'($urandom); reqS[p] = 3'($urandom);
        respRdy[p] = ($urandom % 4 != 0);
        respRty[p] = (rtyCnt[p] == 1);
        if (rtyCnt[p] != 0) rtyCnt[p]--;
      end
      mReqReady = ($urandom % 4 != 0);
      mReqRetry = (mRtyCnt == 1);
      if (mRtyCnt != 0) mRtyCnt--;
      mRespValid = (latCnt == 1);
      mRespFetch = memTag;
      mRespData = memVal(memAddr);
      if (latCnt != 0) latCnt--;
      #5;
      if (protoErr) errSeen++;
      for (int p = 0; p < 2; p++) begin
        if (retryP[p] && st[p] == 1) st[p] = 0;
        if (reqV[p]) begin
          if (reqRdy[p]) begin st[p] = 2; expA[p] = reqA[p]; end
          else st[p] = 1;
        end
      end
      for (int p = 0; p < 2; p++) begin
        if (respV[p]) begin
          chk(st[p] == 2 && respD[p] == memVal(expA[p]), p == 0 ? "R6 random instr response" : "R6 random data response",
              respD[p], memVal(expA[p]));
          if (respRdy[p]) begin st[p] = 0; completed++; end
          else rtyCnt[p] = 1 + int'($urandom % 3);
        end
      end
      if (mReqValid) begin
        if (mReqReady) begin
          chk(mReqAddr == expA[mReqFetch ? 0 : 1], "R2 random forward", mReqAddr, expA[mReqFetch ? 0 : 1]);
          memAddr = mReqAddr; memTag = mReqFetch; latCnt = 1 + int'($urandom % 4);
        end else mRtyCnt = 1 + int'($urandom % 3);
      end
    end
    chk(errSeen == 0, "R9 no error on legal traffic", 32'(errSeen), 0);
    chk(completed > 100, "R8 traffic progresses through retries", 32'(completed), 100);
    finishRun();
  end
endmodule